// File: doc/BRIEF.md
# Serial-Access Converter Control Sequencer

This block is the digital control of a multi-channel converter that a host reaches over a three-wire serial link: an active-low select, a host-driven I/O clock and a serial address line. It is modelled from the converter's side and runs on a free-running internal system clock. Both host inputs are sampled on that clock. During each access the block shifts out the result of the previous conversion. At the same time it takes in the 4-bit address of the channel to convert next. It then times a sampling phase and a conversion phase and signals completion on an end-of-conversion flag.

The analog converter core is replaced by a behavioural successive-approximation engine. The engine resolves, one bit per system clock, an 8-bit code taken from a per-channel test input. Any address at or above the channel count selects a built-in self-test code near mid-scale. The serial output is a data bit plus a pad-enable. A low enable stands for the high-impedance state.

Top module: `serial_adc_seq`

## Requirements
- R1: After reset the output enable is low, the end-of-conversion flag is high and the stored result is 00000000, so the first access shifts out 00000000.
- R2: A low level on `cs_ni` is recognised at the third consecutive system-clock edge on which it is sampled low, and the output enable rises at that edge. A low pulse sampled on only two edges is never recognised.
- R3: At the first clock edge that samples `cs_ni` high, the output enable drops. An access cut short this way starts no conversion. While `cs_ni` is high, I/O clock and address activity has no effect: the flag stays high and the next access returns the unchanged result.
- R4: When an access is recognised, `dout_o` carries bit 7 (MSB) of the stored result.
- R5: The first four rising I/O clock edges of an access shift in the channel address, MSB first. Later rising edges in the same access are ignored.
- R6: Falling I/O clock edges one to seven each advance `dout_o` to the next lower result bit, from bit 6 down to bit 0.
- R7: At the system-clock edge that sees the eighth falling I/O clock edge, the output enable and the end-of-conversion flag both go low.
- R8: The flag rises exactly SAMP_CYC + CONV_CYC system clocks after that edge (32 by default). The new result is then the code of the addressed channel, latched at the end of the sampling phase.
- R9: Addresses 0 to 10 select the matching channel input. Addresses 11 (1011) to 15 select the self-test code, which is 10000000 by default.
- R10: An access recognised while a sampling or conversion phase runs aborts that conversion. The access returns the older stored result, and the flag stays low until a later conversion completes.
- R11: If `cs_ni` is still low when a conversion completes, a new access starts at that same edge. The enable goes high and `dout_o` shows the MSB of the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select from the host |
| io_clk_i | input | 1 | Host serial I/O clock |
| addr_i | input | 1 | Serial channel address, MSB first |
| chan_codes_i | input | NUM_CH*DATA_W | Behavioural code per channel, channel 0 in the low byte |
| dout_o | output | 1 | Serial result bit, 0 when not enabled |
| dout_en_o | output | 1 | Output pad enable, low means high-impedance |
| eoc_o | output | 1 | End-of-conversion flag |

## Verification
The bench uses the default parameters: 8-bit results, 4-bit addresses, 11 channels, a three-edge select qualifier, a 12-clock sampling phase and a 20-clock conversion phase. With these values the exact 32-clock conversion latency can be counted edge by edge. An abort 16 clocks into a conversion lands before completion. The self-test range (addresses 11 to 15) sits directly above the last real channel, so both sides of the boundary are exercised. Channel codes 11111111 and 00000000 push the successive-approximation engine to both ends of its range.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_SAMPLE,
    ST_CONV
  } sadc_state_e;
endpackage

// File: rtl/sadc_cs_filter.sv
module sadc_cs_filter #(
  parameter int QUAL = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  output logic active_o,
  output logic rec_o
);
  localparam int CW = $clog2(QUAL + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign rec_o    = !cs_ni && !act_q && (cnt_q == CW'(QUAL - 1));
  assign active_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cs_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (rec_o) begin
      act_q <= 1'b1;
    end else if (!act_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_edge_det.sv
module sadc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/sadc_chan_mux.sv
module sadc_chan_mux #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter int                NUM_CH    = 11,
  parameter logic [DATA_W-1:0] SELF_CODE = 8'h80
) (
  input  logic [ADDR_W-1:0]        sel_i,
  input  logic [NUM_CH*DATA_W-1:0] codes_i,
  output logic [DATA_W-1:0]        code_o
);
  always_comb begin
    code_o = SELF_CODE;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_i == ADDR_W'(i)) code_o = codes_i[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] hold_q, sar_q, mask_q;
  logic [DATA_W-1:0] trial;

  assign trial    = sar_q | mask_q;
  assign result_o = sar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sar_q  <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      hold_q <= code_i;
      sar_q  <= '0;
      mask_q <= {1'b1, {(DATA_W-1){1'b0}}};
    end else if (step_i && (mask_q != '0)) begin
      // keep the trial bit when the held code is not below it
      if (trial <= hold_q) sar_q <= trial;
      mask_q <= mask_q >> 1;
    end
  end
endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter int                NUM_CH    = 11,
  parameter logic [DATA_W-1:0] SELF_CODE = 8'h80,
  parameter int                CS_QUAL   = 3,
  parameter int                SAMP_CYC  = 12,
  parameter int                CONV_CYC  = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_ni,
  input  logic                     io_clk_i,
  input  logic                     addr_i,
  input  logic [NUM_CH*DATA_W-1:0] chan_codes_i,
  output logic                     dout_o,
  output logic                     dout_en_o,
  output logic                     eoc_o
);
  import sadc_pkg::*;

  localparam int RW    = $clog2(ADDR_W + 1);
  localparam int FW    = $clog2(DATA_W);
  localparam int MAXPH = (SAMP_CYC > CONV_CYC) ? SAMP_CYC : CONV_CYC;
  localparam int PW    = $clog2(MAXPH + 1);

  sadc_state_e       state_q;
  logic [RW-1:0]     rise_cnt_q;
  logic [FW-1:0]     fall_cnt_q;
  logic [ADDR_W-1:0] addr_sr_q, ch_q;
  logic [DATA_W-1:0] out_sr_q, result_q;
  logic [PW-1:0]     phase_q;
  logic              eoc_q;

  logic cs_act, cs_rec, io_rise, io_fall;
  logic sar_load, sar_step;
  logic [DATA_W-1:0] ch_code, sar_res;

  sadc_cs_filter #(.QUAL(CS_QUAL)) u_cs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .active_o (cs_act),
    .rec_o    (cs_rec)
  );

  sadc_edge_det u_ioc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (io_clk_i),
    .rise_o (io_rise),
    .fall_o (io_fall)
  );

  sadc_chan_mux #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_CH    (NUM_CH),
    .SELF_CODE (SELF_CODE)
  ) u_mux (
    .sel_i   (ch_q),
    .codes_i (chan_codes_i),
    .code_o  (ch_code)
  );

  assign sar_load = (state_q == ST_SAMPLE) && (phase_q == PW'(SAMP_CYC - 1));
  assign sar_step = (state_q == ST_CONV) && (phase_q < PW'(DATA_W));

  sadc_sar #(.DATA_W(DATA_W)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (sar_load),
    .code_i   (ch_code),
    .step_i   (sar_step),
    .result_o (sar_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rise_cnt_q <= '0;
      fall_cnt_q <= '0;
      addr_sr_q  <= '0;
      ch_q       <= '0;
      out_sr_q   <= '0;
      result_q   <= '0;
      phase_q    <= '0;
      eoc_q      <= 1'b1;
    end else if (cs_rec) begin
      // fresh access; also aborts any running sample or conversion
      state_q    <= ST_SHIFT;
      out_sr_q   <= result_q;
      rise_cnt_q <= '0;
      fall_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_SHIFT: begin
          if (cs_ni) begin
            state_q <= ST_IDLE;
          end else begin
            if (io_rise && (rise_cnt_q < RW'(ADDR_W))) begin
              addr_sr_q  <= {addr_sr_q[ADDR_W-2:0], addr_i};
              rise_cnt_q <= rise_cnt_q + 1'b1;
            end
            if (io_fall) begin
              if (fall_cnt_q == FW'(DATA_W - 1)) begin
                state_q <= ST_SAMPLE;
                phase_q <= '0;
                eoc_q   <= 1'b0;
              end else begin
                out_sr_q   <= out_sr_q << 1;
                fall_cnt_q <= fall_cnt_q + 1'b1;
                if (fall_cnt_q == FW'(ADDR_W - 1)) ch_q <= addr_sr_q;
              end
            end
          end
        end
        ST_SAMPLE: begin
          if (phase_q == PW'(SAMP_CYC - 1)) begin
            state_q <= ST_CONV;
            phase_q <= '0;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (phase_q == PW'(CONV_CYC - 1)) begin
            result_q <= sar_res;
            eoc_q    <= 1'b1;
            if (cs_act && !cs_ni) begin
              state_q    <= ST_SHIFT;
              out_sr_q   <= sar_res;
              rise_cnt_q <= '0;
              fall_cnt_q <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dout_en_o = (state_q == ST_SHIFT);
  assign dout_o    = dout_en_o & out_sr_q[DATA_W-1];
  assign eoc_o     = eoc_q;
endmodule

// File: rtl/sadc_chk.sv
module sadc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic dout_en_o,
  input logic eoc_o
);
  // R3
  cs_high_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !dout_en_o);

  // R2
  en_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_en_o) |-> !$past(cs_ni));

  // R7
  eoc_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eoc_o) |-> $fell(dout_en_o));

  // R7
  end_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dout_en_o) && !$past(cs_ni)) |-> !eoc_o);

  // R8
  eoc_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_o) |-> !$past(dout_en_o));
endmodule

bind serial_adc_seq sadc_chk u_sadc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .dout_en_o (dout_en_o),
  .eoc_o     (eoc_o)
);

// File: tb/serial_adc_seq_tb_top.sv
module serial_adc_seq_tb_top;
  localparam int HP = 3;
  localparam int CONV_TOTAL = 1 + 12 + 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic io_clk = 1'b0;
  logic addr = 1'b0;
  logic [7:0] codes [11];
  logic [87:0] codes_flat;
  logic dout, dout_en, eoc;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 11; i++) codes_flat[i*8 +: 8] = codes[i];
  end

  serial_adc_seq dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cs_ni        (cs_n),
    .io_clk_i     (io_clk),
    .addr_i       (addr),
    .chan_codes_i (codes_flat),
    .dout_o       (dout),
    .dout_en_o    (dout_en),
    .eoc_o        (eoc)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] code_of(input logic [3:0] a);
    return (a < 4'd11) ? codes[a] : 8'h80;
  endfunction

  task automatic select_low();
    cs_n = 1'b1;
    negs(2);
    cs_n = 1'b0;
    negs(3);
  endtask

  // full 8-clock access; ends one clock after the 8th falling edge
  task automatic do_access(input logic [3:0] a, input bit new_cs, output logic [7:0] got);
    if (new_cs) select_low();
    chk("R4 enable at access start", dout_en, 1);
    got[7] = dout;
    for (int i = 0; i < 8; i++) begin
      addr = (i < 4) ? a[3-i] : ~a[i-4]; // R5: bits after the fourth are junk
      io_clk = 1'b1;
      negs(HP);
      io_clk = 1'b0;
      if (i < 7) begin
        negs(HP);
        got[6-i] = dout;
      end else begin
        negs(1);
        chk("R7 enable low after 8th fall", dout_en, 0);
        chk("R7 eoc low after 8th fall", eoc, 0);
      end
    end
  endtask

  task automatic wait_conv();
    int k = 1;
    while (!eoc && k < 200) begin
      negs(1);
      k++;
    end
    chk("R8 conversion latency", k, CONV_TOTAL);
  endtask

  task automatic t_reset();
    logic [7:0] got;
    chk("R1 reset enable", dout_en, 0);
    chk("R1 reset eoc", eoc, 1);
    do_access(4'd3, 1'b1, got);
    chk("R1 R4 first result zero", got, 8'h00);
    wait_conv();
  endtask

  task automatic t_cs_filter();
    logic [7:0] got;
    cs_n = 1'b1;
    negs(2);
    cs_n = 1'b0;
    negs(2);
    chk("R2 short low not recognised", dout_en, 0);
    cs_n = 1'b1;
    negs(3);
    chk("R2 short pulse ignored", dout_en, 0);
    cs_n = 1'b0;
    negs(1);
    chk("R2 edge1", dout_en, 0);
    negs(1);
    chk("R2 edge2", dout_en, 0);
    negs(1);
    chk("R2 edge3 recognised", dout_en, 1);
    do_access(4'd10, 1'b0, got);
    chk("R6 R8 channel 3 result", got, code_of(4'd3));
    wait_conv();
    cs_n = 1'b1;
    negs(1);
  endtask

  task automatic t_cs_high_ignored();
    logic [7:0] got;
    cs_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      addr = i[0];
      io_clk = 1'b1;
      negs(HP);
      io_clk = 1'b0;
      negs(HP);
      chk("R3 no enable while deselected", dout_en, 0);
    end
    chk("R3 eoc unchanged", eoc, 1);
    do_access(4'd11, 1'b1, got);
    chk("R3 result unchanged (ch10)", got, code_of(4'd10));
    wait_conv();
  endtask

  task automatic t_self_test();
    logic [7:0] got;
    do_access(4'd15, 1'b1, got);
    chk("R9 address 1011 self-test", got, 8'h80);
    wait_conv();
    do_access(4'd0, 1'b1, got);
    chk("R9 address 1111 self-test", got, 8'h80);
    wait_conv();
    do_access(4'd1, 1'b1, got);
    chk("R9 R8 channel 0 full scale", got, 8'hFF);
    wait_conv();
    do_access(4'd2, 1'b1, got);
    chk("R9 R8 channel 1 zero", got, 8'h00);
    wait_conv();
  endtask

  task automatic t_abort();
    logic [7:0] got;
    do_access(4'd6, 1'b1, got);
    chk("R10 ch2 result", got, code_of(4'd2));
    negs(10);
    do_access(4'd7, 1'b1, got);
    chk("R10 aborted returns older result", got, code_of(4'd2));
    wait_conv();
    do_access(4'd8, 1'b1, got);
    chk("R10 restarted conversion ch7", got, code_of(4'd7));
    wait_conv();
  endtask

  task automatic t_cut_access();
    logic [7:0] got;
    select_low();
    for (int i = 0; i < 3; i++) begin
      io_clk = 1'b1;
      negs(HP);
      io_clk = 1'b0;
      negs(HP);
    end
    cs_n = 1'b1;
    negs(1);
    chk("R3 enable drops on cs high", dout_en, 0);
    negs(40);
    chk("R3 cut access starts no conversion", eoc, 1);
    do_access(4'd4, 1'b1, got);
    chk("R3 result kept (ch8)", got, code_of(4'd8));
    wait_conv();
  endtask

  task automatic t_held_low();
    logic [7:0] got;
    // cs still low after previous access
    chk("R11 enable at completion", dout_en, 1);
    chk("R11 MSB of new result", dout, code_of(4'd4) >> 7);
    do_access(4'd5, 1'b0, got);
    chk("R11 chained access ch4", got, code_of(4'd4));
    wait_conv();
    do_access(4'd9, 1'b1, got);
    chk("R11 chained conversion ch5", got, code_of(4'd5));
    wait_conv();
  endtask

  initial begin
    for (int i = 0; i < 11; i++) codes[i] = 8'((i * 37 + 11) & 8'hFF);
    codes[0] = 8'hFF;
    codes[1] = 8'h00;
    codes[3] = 8'hA5;
    negs(3);
    rst_n = 1'b1;
    negs(2);
    t_reset();
    t_cs_filter();
    t_cs_high_ignored();
    t_self_test();
    t_abort();
    t_cut_access();
    t_held_low();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule